// File: doc/BRIEF.md
# Resume-Flag Instruction Breakpoint Filter

This block holds the resume flag, a one-bit state that masks instruction-address breakpoints for a single instruction. An instruction can then be restarted after the debug exception it caused, and the same breakpoint does not fire a second time. The block has a small bank of breakpoint address slots, and each slot has its own enable bit. At every instruction start, the fetch address is compared with the enabled slots. A match is turned into a one-cycle debug exception, but only when the resume flag is clear.

The block also supplies the flag value that is written into the saved flags image when an exception or interrupt is entered. This value depends on the event class and on whether the event interrupted a repeated string instruction before its final iteration. An interrupt return or a task switch reloads the live flag from bit 16 of a saved flags image. A flags-pop instruction leaves the flag untouched. Data and I/O breakpoint conditions pass through unchanged, whatever the flag holds.

Top module: `rf_bp_filter`

## Requirements
- R1: After reset the live flag `rf` is 0 and `insn_bp_exc` is 0.
- R2: When `insn_start` is high, `rf` is 0 and `insn_addr` equals the address of an enabled slot, `insn_bp_exc` is 1 in the cycle after that start, for exactly one cycle. `insn_bp_hits` then shows one bit per matching slot (bit i is slot i).
- R3: A slot whose enable bit is 0, or whose address differs from the fetch address, never raises `insn_bp_exc`.
- R4: While `rf` is 1, instruction breakpoint matches are ignored, and `data_bp_exc` still follows `data_bp_cond` in the same cycle.
- R5: An instruction start clears `rf` in the following cycle. The breakpoint check for that start uses the flag value from before the clear.
- R6: A successful retire (`insn_retire`) clears `rf` in the following cycle.
- R7: `ret_load` (interrupt return or task switch) sets `rf` to bit 16 of `ret_image`. No other bit of the image affects it.
- R8: `flags_pop` has no effect on `rf`.
- R9: When `ret_load` falls in the same cycle as `insn_start` or `insn_retire`, the loaded value wins.
- R10: On `evt_enter` with `evt_class` 0 (fault), `evt_rf_push` is 1 in the same cycle.
- R11: On `evt_enter` with `evt_class` 1 (debug exception from an instruction breakpoint), `evt_rf_push` equals `rf`.
- R12: On `evt_enter` with `evt_class` 2 (hardware interrupt) or 3 (trap), `evt_rf_push` is 1 when `evt_mid_string` is 1. Otherwise it equals `rf`.
- R13: On `evt_enter` with `evt_class` 4 (software interrupt), `evt_rf_push` equals `rf`, which is 0 after the instruction start that began the software interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bp_wr | input | 1 | Write strobe for one breakpoint slot |
| bp_wr_slot | input | 2 | Slot selected for the write |
| bp_wr_addr | input | 32 | Address written into the slot |
| bp_wr_en | input | 1 | Enable bit written into the slot |
| insn_start | input | 1 | An instruction begins |
| insn_addr | input | 32 | Address of the instruction that begins |
| insn_retire | input | 1 | An instruction completed successfully |
| ret_load | input | 1 | Interrupt return or task switch reloads the flag |
| ret_image | input | 32 | Saved flags image, with the flag at bit 16 |
| flags_pop | input | 1 | A flags-pop instruction executes |
| evt_enter | input | 1 | Entry into an exception or interrupt handler |
| evt_class | input | 3 | Class of the event being entered |
| evt_mid_string | input | 1 | Event arrived before the last iteration of a repeated string instruction |
| data_bp_cond | input | 1 | Data or I/O breakpoint condition from elsewhere |
| rf | output | 1 | Live resume flag |
| insn_bp_exc | output | 1 | Instruction-breakpoint debug exception pulse |
| insn_bp_hits | output | 4 | Slots that matched for the pulse |
| data_bp_exc | output | 1 | Data or I/O breakpoint report |
| evt_rf_push | output | 1 | Flag value to record for the event being entered |

## Verification
Two things can happen in the same cycle: the reload from a return image, and the clear caused by an instruction start or retire. This happens when an instruction start is also the return itself. The bench raises `ret_load`, `insn_start` and `insn_retire` together, once with image bit 16 set and once with it clear. It expects the loaded value in the following cycle. In the set case the same start targets an enabled slot with the flag at 0, so the debug pulse must still fire, because the check is made against the flag value from before that edge.

// File: rtl/rf_bp_filter.sv
module rf_bp_filter #(
  parameter int NBP    = 4,
  parameter int AW     = 32,
  parameter int FW     = 32,
  parameter int RF_POS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bp_wr,
  input  logic [$clog2(NBP)-1:0] bp_wr_slot,
  input  logic [AW-1:0]        bp_wr_addr,
  input  logic                 bp_wr_en,
  input  logic                 insn_start,
  input  logic [AW-1:0]        insn_addr,
  input  logic                 insn_retire,
  input  logic                 ret_load,
  input  logic [FW-1:0]        ret_image,
  input  logic                 flags_pop,
  input  logic                 evt_enter,
  input  logic [2:0]           evt_class,
  input  logic                 evt_mid_string,
  input  logic                 data_bp_cond,
  output logic                 rf,
  output logic                 insn_bp_exc,
  output logic [NBP-1:0]       insn_bp_hits,
  output logic                 data_bp_exc,
  output logic                 evt_rf_push
);
  localparam logic [2:0] C_FAULT = 3'd0;
  localparam logic [2:0] C_IBP   = 3'd1;
  localparam logic [2:0] C_INTR  = 3'd2;
  localparam logic [2:0] C_TRAP  = 3'd3;
  localparam logic [2:0] C_SOFT  = 3'd4;
  localparam int SW = $clog2(NBP);

  logic [NBP-1:0] match;
  logic           rf_q;
  logic           unused_inputs;

  assign unused_inputs = ^{ret_image, flags_pop};

  for (genvar g = 0; g < NBP; g++) begin : g_slot
    logic [AW-1:0] addr_q;
    logic          en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (bp_wr && bp_wr_slot == SW'(g)) begin
        addr_q <= bp_wr_addr;
        en_q   <= bp_wr_en;
      end
    end
    assign match[g] = en_q && (addr_q == insn_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q         <= 1'b0;
      insn_bp_exc  <= 1'b0;
      insn_bp_hits <= '0;
    end else begin
      if (ret_load)                       rf_q <= ret_image[RF_POS];
      else if (insn_start || insn_retire) rf_q <= 1'b0;
      insn_bp_exc  <= insn_start && !rf_q && |match;
      insn_bp_hits <= (insn_start && !rf_q) ? match : '0;
    end
  end

  assign rf          = rf_q;
  assign data_bp_exc = data_bp_cond;

  always_comb begin
    unique case (evt_class)
      C_FAULT:        evt_rf_push = 1'b1;
      C_IBP:          evt_rf_push = rf_q;
      C_INTR, C_TRAP: evt_rf_push = evt_mid_string ? 1'b1 : rf_q;
      C_SOFT:         evt_rf_push = rf_q;
      default:        evt_rf_push = rf_q;
    endcase
  end

  assert_reset_clean_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !rf && !insn_bp_exc);

  assert_pulse_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_bp_exc |-> $past(insn_start) && $past(|match));

  assert_suppressed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    insn_bp_exc |-> !$past(rf_q));

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start && !ret_load |=> !rf);

  assert_retire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_retire && !ret_load |=> !rf);

  assert_reload_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_load |=> rf == $past(ret_image[RF_POS]));

  assert_pop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_pop && !ret_load && !insn_start && !insn_retire |=> $stable(rf));

  assert_fault_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter && evt_class == C_FAULT |-> evt_rf_push);

  assert_mid_string_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter && (evt_class == C_INTR || evt_class == C_TRAP) && evt_mid_string |-> evt_rf_push);
endmodule

// File: tb/rf_bp_filter_tb.sv
module rf_bp_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bp_wr = 0; logic [1:0] bp_wr_slot = 0; logic [31:0] bp_wr_addr = 0; logic bp_wr_en = 0;
  logic insn_start = 0; logic [31:0] insn_addr = 0; logic insn_retire = 0;
  logic ret_load = 0; logic [31:0] ret_image = 0; logic flags_pop = 0;
  logic evt_enter = 0; logic [2:0] evt_class = 0; logic evt_mid_string = 0; logic data_bp_cond = 0;
  logic rf, insn_bp_exc, data_bp_exc, evt_rf_push; logic [3:0] insn_bp_hits;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_bp_filter dut_i (.clk(clk), .rst_n(rst_n), .bp_wr(bp_wr), .bp_wr_slot(bp_wr_slot),
    .bp_wr_addr(bp_wr_addr), .bp_wr_en(bp_wr_en), .insn_start(insn_start), .insn_addr(insn_addr),
    .insn_retire(insn_retire), .ret_load(ret_load), .ret_image(ret_image), .flags_pop(flags_pop),
    .evt_enter(evt_enter), .evt_class(evt_class), .evt_mid_string(evt_mid_string),
    .data_bp_cond(data_bp_cond), .rf(rf), .insn_bp_exc(insn_bp_exc), .insn_bp_hits(insn_bp_hits),
    .data_bp_exc(data_bp_exc), .evt_rf_push(evt_rf_push));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_rf(logic v);
    ret_load = 1; ret_image = v ? 32'h5A5B_C3C3 : 32'h5A5A_C3C3; step(); ret_load = 0;
  endtask

  function automatic logic [31:0] slot_addr(int i);
    return 32'h0000_1000 + 32'(i) * 32'h40;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 rf", rf, 0); chk("R1 exc", insn_bp_exc, 0);
    rst_n = 1; step();
    chk("R1 rf after release", rf, 0);

    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 4; s++) begin
        bp_wr = 1; bp_wr_slot = 2'(s); bp_wr_addr = slot_addr(s); bp_wr_en = m[s]; step();
      end
      bp_wr = 0;
      for (int p = 0; p < 5; p++) begin
        for (int r = 0; r < 2; r++) begin
          logic exp_hit;
          set_rf(r[0]);
          insn_addr = (p < 4) ? slot_addr(p) : 32'h0000_2000;
          exp_hit = (r == 0) && (p < 4) && m[p];
          data_bp_cond = 1; #1;
          chk("R4 data bp passes", data_bp_exc, 1);
          data_bp_cond = 0;
          insn_start = 1; step(); insn_start = 0;
          chk(exp_hit ? "R2 hit" : (r == 1 ? "R4 suppressed" : "R3 no hit"), insn_bp_exc, exp_hit);
          chk("R2 hits mask", insn_bp_hits, exp_hit ? (32'd1 << p) : 0);
          chk("R5 start clears", rf, 0);
          step();
          chk("R2 single cycle", insn_bp_exc, 0);
        end
      end
    end

    set_rf(1); insn_addr = slot_addr(0); insn_start = 1; step(); insn_start = 0;
    chk("R5 suppressed once", insn_bp_exc, 0);
    insn_start = 1; step(); insn_start = 0;
    chk("R5 fires on next start", insn_bp_exc, 1);

    set_rf(1); insn_retire = 1; step(); insn_retire = 0;
    chk("R6 retire clears", rf, 0);

    for (int v = 0; v < 16; v++) begin
      logic [31:0] img;
      img = 32'hC0DE_0000 ^ (32'(v) << 14) ^ 32'(v * 37);
      ret_load = 1; ret_image = img; step(); ret_load = 0;
      chk("R7 load bit16", rf, img[16]);
    end

    set_rf(1); flags_pop = 1; ret_image = 32'h0; step(); flags_pop = 0;
    chk("R8 pop keeps 1", rf, 1);
    set_rf(0); flags_pop = 1; ret_image = 32'hFFFF_FFFF; step(); flags_pop = 0;
    chk("R8 pop keeps 0", rf, 0);

    set_rf(0); insn_addr = slot_addr(0);
    ret_load = 1; ret_image = 32'h0001_0000; insn_start = 1; insn_retire = 1; step();
    ret_load = 0; insn_start = 0; insn_retire = 0;
    chk("R9 load wins 1", rf, 1);
    chk("R9 check uses old flag", insn_bp_exc, 1);
    ret_load = 1; ret_image = 32'hFFFE_FFFF; insn_start = 1; insn_retire = 1; step();
    ret_load = 0; insn_start = 0; insn_retire = 0;
    chk("R9 load wins 0", rf, 0);
    chk("R9 suppressed by old flag", insn_bp_exc, 0);

    for (int c = 0; c < 5; c++) begin
      for (int r = 0; r < 2; r++) begin
        for (int ms = 0; ms < 2; ms++) begin
          logic exp_p;
          set_rf(r[0]);
          evt_enter = 1; evt_class = 3'(c); evt_mid_string = ms[0]; #1;
          case (c)
            0: exp_p = 1;
            2, 3: exp_p = ms[0] ? 1'b1 : r[0];
            default: exp_p = r[0];
          endcase
          chk(c == 0 ? "R10 fault push" : c == 1 ? "R11 ibp push" :
              c == 4 ? "R13 soft push" : "R12 intr/trap push", evt_rf_push, exp_p);
          evt_enter = 0; step();
        end
      end
    end

    set_rf(1); insn_addr = 32'h3000; insn_start = 1; step(); insn_start = 0;
    evt_enter = 1; evt_class = 3'd4; #1;
    chk("R13 soft int after start", evt_rf_push, 0);
    evt_enter = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule